// File: doc/BRIEF.md
# Binary Associative Memory Matrix

This block is a correlation-matrix associative memory built from one-bit cells arranged in key rows and value columns. A learning operation presents a key vector and a value vector together; every cell whose row bit in the key and column bit in the value are both 1 is set, and no cell is ever cleared by learning. Storing several pairs therefore superposes them in the same matrix.

A recall operation presents a key vector alone. For every column the block counts the set cells lying in rows whose key bit is 1, compares that count with a programmable threshold, and produces one output bit per column. Every cell takes part in parallel, so a full learning step or a full recall completes in one clock. The result is registered and announced with a one-cycle valid pulse; a synchronous clear empties the matrix in a single clock.

Top module: `bam_matrix`

## Requirements
- R1: While reset (active low) is asserted and on the first clock after it, every cell is 0, the output vector is 0, the valid output is 0 and the threshold register holds 1.
- R2: A learn operation (learn strobe high, clear low) sets cell (i,j) to its old value OR (learn key bit i AND learn value bit j), for all cells in the same clock.
- R3: Apart from clear, no operation ever changes a cell from 1 to 0; successive learned pairs accumulate.
- R4: A recall forms, for each column j, the count of set cells in column j over rows i with recall key bit i equal to 1, and output bit j is 1 exactly when that count is greater than or equal to the threshold.
- R5: A threshold write stores the written value in the threshold register on the next clock edge; a value above the row count is stored as the row count. A recall in the same cycle as a write uses the old threshold.
- R6: With a threshold of 0, a recall drives every output bit to 1, whatever the key or the contents.
- R7: The recall result appears on the output one clock after the recall strobe, together with a valid pulse lasting one cycle; back-to-back recalls each give their own result and pulse; between recalls the output vector holds its last value and valid stays 0.
- R8: When learn and recall are strobed in the same cycle, the learn takes place and the recall is ignored: no valid pulse and no change of the output vector.
- R9: A clear strobe sets every cell to 0 in one clock; clear takes priority over learn and recall, both of which are ignored in that cycle.
- R10: A recall with an all-zero key gives an all-zero output whenever the threshold is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Empty the whole matrix |
| learn_i | input | 1 | Learn strobe |
| learn_key_i | input | ROWS | Key vector of the pair being stored |
| learn_val_i | input | COLS | Value vector of the pair being stored |
| recall_i | input | 1 | Recall strobe |
| recall_key_i | input | ROWS | Key vector for recall |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_data_i | input | CW | Threshold value to write |
| out_vec_o | output | COLS | Registered recall result, one wire per column |
| out_valid_o | output | 1 | One-cycle pulse marking a new recall result |

## Verification
The matrix is only visible through recall, so a wrong cell shows up as a wrong output bit on the first recall whose key selects that cell's row and whose threshold lies at the column's count boundary; the stimulus therefore steps the threshold across counts of 1 to 8 so that a single extra or missing cell flips a bit. A mishandled strobe priority shows one clock later as a stray or missing valid pulse, and a learn or clear that was wrongly taken or dropped shows on the next recall. Threshold clamping and the threshold of 0 are checked at the extremes of the count range.

// File: rtl/bam_pkg.sv
// Shared definitions for the binary associative memory.
// Assumes: one operation on the matrix per clock, chosen by strobe priority.
package bam_pkg;

    // Matrix operation selected for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_LEARN  = 2'd2,
        OP_RECALL = 2'd3
    } bam_op_e;

    // Bits needed to hold any count from 0 up to n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bam_ctrl.sv
// Strobe decoder and threshold register.
// Picks one matrix operation per cycle (clear > learn > recall) and keeps
// the recall threshold, clamped to the row count on write.
// Assumes: strobes are synchronous single-cycle or level signals.
module bam_ctrl #(
    parameter int ROWS = 8,
    parameter int CW   = bam_pkg::count_width(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  learn_i,
    input  logic                  recall_i,
    input  logic                  thr_wr_i,
    input  logic [CW-1:0]         thr_data_i,
    output bam_pkg::bam_op_e      op_o,
    output logic [CW-1:0]         thr_o
);
    import bam_pkg::*;

    localparam logic [CW-1:0] THR_MAX   = CW'(ROWS);
    localparam logic [CW-1:0] THR_RESET = CW'(1);

    logic [CW-1:0] thr_q;
    logic [CW-1:0] thr_clamped;

    // Priority decode of the strobes into a single operation.
    always_comb begin
        if (clear_i)       op_o = OP_CLEAR;
        else if (learn_i)  op_o = OP_LEARN;
        else if (recall_i) op_o = OP_RECALL;
        else               op_o = OP_IDLE;
    end

    // Limit a written threshold to the largest reachable count.
    always_comb begin
        thr_clamped = (thr_data_i > THR_MAX) ? THR_MAX : thr_data_i;
    end

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_q <= THR_RESET;
        else if (thr_wr_i) thr_q <= thr_clamped;
    end

    assign thr_o = thr_q;

endmodule

// File: rtl/bam_row.sv
// One key row of the matrix: COLS one-bit cells.
// On learn with this row's key bit set, ORs the value vector into the row;
// on clear, empties the row. Cells never clear otherwise.
module bam_row #(
    parameter int COLS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bam_pkg::bam_op_e      op_i,
    input  logic                  key_bit_i,
    input  logic [COLS-1:0]       val_i,
    output logic [COLS-1:0]       cells_o
);
    import bam_pkg::*;

    logic [COLS-1:0] cells_q;

    // Cell storage: clear, accumulate, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cells_q <= '0;
        else if (op_i == OP_CLEAR)
            cells_q <= '0;
        else if (op_i == OP_LEARN && key_bit_i)
            cells_q <= cells_q | val_i;
    end

    assign cells_o = cells_q;

endmodule

// File: rtl/bam_column.sv
// One value column of the recall path: counts set cells in rows selected
// by the key and compares the count with the threshold.
// Purely combinational; the result is registered by the top level.
module bam_column #(
    parameter int ROWS = 8,
    parameter int CW   = bam_pkg::count_width(ROWS)
) (
    input  logic [ROWS-1:0]       col_bits_i,
    input  logic [ROWS-1:0]       key_i,
    input  logic [CW-1:0]         thr_i,
    output logic                  hit_o
);
    logic [CW-1:0] count;

    // Population count of the selected cells in this column.
    always_comb begin
        count = '0;
        for (int r = 0; r < ROWS; r++) begin
            count = count + CW'(col_bits_i[r] & key_i[r]);
        end
    end

    // Threshold decision.
    always_comb begin
        hit_o = (count >= thr_i);
    end

endmodule

// File: rtl/bam_matrix.sv
// Binary associative memory: ROWS x COLS one-bit cells, learned by OR of
// the key/value outer product and recalled by per-column thresholded
// counts. All cells work in parallel; one operation per clock.
// Assumes: single clock domain, synchronous active-low reset.
module bam_matrix #(
    parameter int ROWS = 8,
    parameter int COLS = 10,
    parameter int CW   = bam_pkg::count_width(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              learn_i,
    input  logic [ROWS-1:0]   learn_key_i,
    input  logic [COLS-1:0]   learn_val_i,
    input  logic              recall_i,
    input  logic [ROWS-1:0]   recall_key_i,
    input  logic              thr_wr_i,
    input  logic [CW-1:0]     thr_data_i,
    output logic [COLS-1:0]   out_vec_o,
    output logic              out_valid_o
);
    import bam_pkg::*;

    localparam int NCELLS = ROWS * COLS;

    bam_op_e           op;
    logic [CW-1:0]     thr_q;
    logic [COLS-1:0]   row_q [ROWS];
    logic [NCELLS-1:0] cells_flat;
    logic [COLS-1:0]   hits;
    logic [COLS-1:0]   out_q;
    logic              valid_q;

    bam_ctrl #(
        .ROWS (ROWS),
        .CW   (CW)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .learn_i    (learn_i),
        .recall_i   (recall_i),
        .thr_wr_i   (thr_wr_i),
        .thr_data_i (thr_data_i),
        .op_o       (op),
        .thr_o      (thr_q)
    );

    // Storage rows, one per key bit.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        bam_row #(
            .COLS (COLS)
        ) row_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_i      (op),
            .key_bit_i (learn_key_i[r]),
            .val_i     (learn_val_i),
            .cells_o   (row_q[r])
        );
        assign cells_flat[r*COLS +: COLS] = row_q[r];
    end

    // Recall columns, one per value bit.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] cbits;

        // Gather this column's cells across all rows.
        always_comb begin
            for (int r = 0; r < ROWS; r++) begin
                cbits[r] = row_q[r][c];
            end
        end

        bam_column #(
            .ROWS (ROWS),
            .CW   (CW)
        ) col_i (
            .col_bits_i (cbits),
            .key_i      (recall_key_i),
            .thr_i      (thr_q),
            .hit_o      (hits[c])
        );
    end

    // Output register: capture on an accepted recall, pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (op == OP_RECALL);
            if (op == OP_RECALL) out_q <= hits;
        end
    end

    assign out_vec_o   = out_q;
    assign out_valid_o = valid_q;

endmodule

// File: rtl/bam_matrix_chk.sv
// Property checker for bam_matrix, attached by bind.
// Observes strobes, the cell array, the threshold and the outputs.
module bam_matrix_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 10,
    parameter int CW   = bam_pkg::count_width(ROWS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clear_i,
    input logic                   learn_i,
    input logic                   recall_i,
    input logic [ROWS-1:0]        recall_key_i,
    input logic [CW-1:0]          thr_q,
    input logic [ROWS*COLS-1:0]   cells,
    input logic [COLS-1:0]        out_vec_o,
    input logic                   out_valid_o
);
    logic take_recall;
    assign take_recall = recall_i && !learn_i && !clear_i;

    // R7
    recall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_recall |=> out_valid_o);

    // R8
    learn_blocks_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_i || clear_i) |=> !out_valid_o);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> $stable(out_vec_o));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cells == '0));

    // R3
    cells_accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((cells & $past(cells)) == $past(cells)));

    // R6
    thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_recall && thr_q == '0) |=> (out_vec_o == '1));

    // R10
    zero_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_recall && recall_key_i == '0 && thr_q != '0) |=> (out_vec_o == '0));

    // R5
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q <= CW'(ROWS));

endmodule

bind bam_matrix bam_matrix_chk #(
    .ROWS (ROWS),
    .COLS (COLS),
    .CW   (CW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .learn_i      (learn_i),
    .recall_i     (recall_i),
    .recall_key_i (recall_key_i),
    .thr_q        (thr_q),
    .cells        (cells_flat),
    .out_vec_o    (out_vec_o),
    .out_valid_o  (out_valid_o)
);

// File: tb/bam_matrix_tb_top.sv
// Self-checking bench for bam_matrix: a stimulus table walked by one loop,
// then directed tests. Expected values come from a behavioural model.
module bam_matrix_tb_top;

    localparam int ROWS = 8;
    localparam int COLS = 10;
    localparam int CW   = 4;

    localparam logic [1:0] K_LRN = 2'd0;
    localparam logic [1:0] K_RCL = 2'd1;
    localparam logic [1:0] K_THR = 2'd2;
    localparam logic [1:0] K_CLR = 2'd3;

    // {kind, key, value, threshold}
    localparam int NTBL = 16;
    localparam logic [23:0] TBL [NTBL] = '{
        {K_LRN, 8'b0000_0011, 10'b00_0000_0101, 4'd0},
        {K_LRN, 8'b0000_0100, 10'b00_0000_0110, 4'd0},
        {K_RCL, 8'b0000_0001, 10'b0,            4'd0},
        {K_RCL, 8'b0000_0110, 10'b0,            4'd0},
        {K_THR, 8'b0,         10'b0,            4'd2},
        {K_RCL, 8'b0000_0111, 10'b0,            4'd0},
        {K_LRN, 8'b1111_0000, 10'b11_0000_0000, 4'd0},
        {K_THR, 8'b0,         10'b0,            4'd4},
        {K_RCL, 8'b1111_1111, 10'b0,            4'd0},
        {K_THR, 8'b0,         10'b0,            4'd3},
        {K_RCL, 8'b1111_1111, 10'b0,            4'd0},
        {K_CLR, 8'b0,         10'b0,            4'd0},
        {K_RCL, 8'b1111_1111, 10'b0,            4'd0},
        {K_LRN, 8'b1000_0001, 10'b10_0000_0001, 4'd0},
        {K_THR, 8'b0,         10'b0,            4'd2},
        {K_RCL, 8'b1000_0001, 10'b0,            4'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            clear_i, learn_i, recall_i, thr_wr_i;
    logic [ROWS-1:0] learn_key_i, recall_key_i;
    logic [COLS-1:0] learn_val_i;
    logic [CW-1:0]   thr_data_i;
    logic [COLS-1:0] out_vec_o;
    logic            out_valid_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Behavioural model state.
    logic [COLS-1:0] m [ROWS];
    logic [CW-1:0]   mthr;
    logic [COLS-1:0] eout;
    logic            evalid;

    always #10 clk = ~clk;

    bam_matrix #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .learn_i      (learn_i),
        .learn_key_i  (learn_key_i),
        .learn_val_i  (learn_val_i),
        .recall_i     (recall_i),
        .recall_key_i (recall_key_i),
        .thr_wr_i     (thr_wr_i),
        .thr_data_i   (thr_data_i),
        .out_vec_o    (out_vec_o),
        .out_valid_o  (out_valid_o)
    );

    // Model recall per R4 with the current model threshold.
    function automatic logic [COLS-1:0] model_recall(input logic [ROWS-1:0] k);
        logic [COLS-1:0] res;
        for (int c = 0; c < COLS; c++) begin
            int cnt = 0;
            for (int r = 0; r < ROWS; r++) cnt += int'(m[r][c] & k[r]);
            res[c] = (cnt >= int'(mthr));
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [COLS:0] got, input logic [COLS:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/out %b expected %b", tag, got, exp);
        end
    endtask

    // One clock of stimulus from a negedge; returns at the following negedge.
    task automatic step(input logic cl, input logic ln, input logic rc, input logic tw,
                        input logic [ROWS-1:0] lk, input logic [COLS-1:0] lv,
                        input logic [ROWS-1:0] rk, input logic [CW-1:0] td);
        clear_i = cl; learn_i = ln; recall_i = rc; thr_wr_i = tw;
        learn_key_i = lk; learn_val_i = lv; recall_key_i = rk; thr_data_i = td;
        @(posedge clk);
        evalid = rc && !ln && !cl;
        if (evalid) eout = model_recall(rk);
        if (cl) begin
            for (int r = 0; r < ROWS; r++) m[r] = '0;
        end else if (ln) begin
            for (int r = 0; r < ROWS; r++) if (lk[r]) m[r] = m[r] | lv;
        end
        if (tw) mthr = (td > CW'(ROWS)) ? CW'(ROWS) : td;
        @(negedge clk);
        clear_i = 0; learn_i = 0; recall_i = 0; thr_wr_i = 0;
    endtask

    task automatic check_out(input string tag);
        check(tag, {out_valid_o, out_vec_o}, {evalid, eout});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [COLS-1:0] held;
        rst_n = 0;
        clear_i = 0; learn_i = 0; recall_i = 0; thr_wr_i = 0;
        learn_key_i = '0; learn_val_i = '0; recall_key_i = '0; thr_data_i = '0;
        for (int r = 0; r < ROWS; r++) m[r] = '0;
        mthr = CW'(1); eout = '0; evalid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 reset outputs", {out_valid_o, out_vec_o}, '0);
        rst_n = 1;
        // R1: empty matrix, threshold 1 -> nothing reaches it
        step(0, 0, 1, 0, '0, '0, 8'hFF, '0);
        check("R1 empty recall", {out_valid_o, out_vec_o}, {1'b1, 10'b0});

        // Table walk (R2, R3, R4, R5, R9)
        for (int i = 0; i < NTBL; i++) begin
            logic [1:0]      kd;
            logic [ROWS-1:0] ky;
            logic [COLS-1:0] vl;
            logic [CW-1:0]   th;
            {kd, ky, vl, th} = TBL[i];
            case (kd)
                K_LRN: step(0, 1, 0, 0, ky, vl, '0, '0);
                K_RCL: step(0, 0, 1, 0, '0, '0, ky, '0);
                K_THR: step(0, 0, 0, 1, '0, '0, '0, th);
                default: step(1, 0, 0, 0, '0, '0, '0, '0);
            endcase
            if (kd == K_RCL) check_out("R4 R2 R3 table recall");
            else             check("R7 no valid outside recall", {out_valid_o, 10'b0}, {1'b0, 10'b0});
        end

        // R5: over-range threshold clamps to ROWS
        step(1, 0, 0, 0, '0, '0, '0, '0);
        step(0, 1, 0, 0, 8'hFF, 10'h001, '0, '0);
        step(0, 0, 0, 1, '0, '0, '0, 4'd15);
        step(0, 0, 1, 0, '0, '0, 8'hFF, '0);
        check("R5 clamp", {out_valid_o, out_vec_o}, {1'b1, 10'h001});
        // R5: recall in the write cycle uses the old threshold (8)
        step(0, 0, 1, 1, '0, '0, 8'h7F, 4'd1);
        check("R5 old threshold", {out_valid_o, out_vec_o}, {1'b1, 10'h000});

        // R6: threshold 0 forces all ones
        step(0, 0, 0, 1, '0, '0, '0, 4'd0);
        step(0, 0, 1, 0, '0, '0, 8'h00, '0);
        check("R6 zero threshold", {out_valid_o, out_vec_o}, {1'b1, 10'h3FF});

        // R10: zero key with threshold 1
        step(0, 0, 0, 1, '0, '0, '0, 4'd1);
        step(0, 0, 1, 0, '0, '0, 8'h00, '0);
        check("R10 zero key", {out_valid_o, out_vec_o}, {1'b1, 10'h000});

        // R8: learn and recall together -> learn only
        step(0, 0, 1, 0, '0, '0, 8'hFF, '0);
        held = out_vec_o;
        step(0, 1, 1, 0, 8'h02, 10'h100, 8'h02, '0);
        check("R8 recall ignored", {out_valid_o, out_vec_o}, {1'b0, held});
        step(0, 0, 1, 0, '0, '0, 8'h02, '0);
        check("R8 learn applied", {out_valid_o, out_vec_o}, {1'b1, 10'h101});

        // R9: clear beats learn
        step(1, 1, 0, 0, 8'hFF, 10'h3FF, '0, '0);
        step(0, 0, 1, 0, '0, '0, 8'hFF, '0);
        check("R9 clear priority", {out_valid_o, out_vec_o}, {1'b1, 10'h000});

        // R7: back-to-back recalls, then hold
        step(0, 1, 0, 0, 8'h01, 10'h00F, '0, '0);
        step(0, 0, 1, 0, '0, '0, 8'h01, '0);
        check("R7 first recall", {out_valid_o, out_vec_o}, {1'b1, 10'h00F});
        step(0, 0, 1, 0, '0, '0, 8'h00, '0);
        check("R7 second recall", {out_valid_o, out_vec_o}, {1'b1, 10'h000});
        step(0, 0, 1, 0, '0, '0, 8'h01, '0);
        step(0, 0, 0, 0, '0, '0, '0, '0);
        check("R7 hold", {out_valid_o, out_vec_o}, {1'b0, 10'h00F});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule